// File: doc/BRIEF.md
# Two-Lane Residue Subtractor

This block subtracts two numbers held in a residue number system built on the moduli 2^N - 1 and 2^N. Each operand is a pair of N-bit residues: one for the odd modulus 2^N - 1 (the "ones lane") and one for the power-of-two modulus 2^N (the "pow lane"). The two lanes compute their differences side by side. No carry or other signal passes from one lane to the other, so the delay is that of a single N-bit lane.

The pow lane is an ordinary two's complement subtractor. It adds the bitwise inverse of the subtrahend plus one, and it drops the carry out of the top bit. The ones lane works in one's complement arithmetic. It adds the inverted subtrahend to the minuend, then feeds the carry out of that sum back into the least significant bit. A result of all ones is the second code for zero in that lane, so it is folded to zero before it leaves the block.

The block is purely combinational. It has no clock, no handshake and no stored state, and it is meant to sit inside a larger residue datapath. Conversion into and out of residue form belongs to other blocks.

Top module: `rns_pair_sub`

## Requirements
- R1: `diff_pow` equals (`x_pow` - `y_pow`) mod 2^N for every pair of N-bit inputs.
- R2: For `x_ones` and `y_ones` in 0 to 2^N - 2, `diff_ones` equals (`x_ones` - `y_ones`) mod (2^N - 1), taken as a value in 0 to 2^N - 2.
- R3: `diff_ones` is never all ones. Equal ones-lane operands give `diff_ones` = 0.
- R4: An all-ones value on `x_ones` or `y_ones` behaves exactly as the residue 0 does.
- R5: The lanes are independent. Changing only the pow-lane inputs leaves `diff_ones` unchanged, and changing only the ones-lane inputs leaves `diff_pow` unchanged.
- R6: The outputs follow the inputs combinationally, in the same time step and without any clock.
- R7: With N = 4, the operands (`x_ones`, `x_pow`) = (3, 5) and (`y_ones`, `y_pow`) = (7, 9) give (`diff_ones`, `diff_pow`) = (11, 12).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_ones | input | N | Minuend residue modulo 2^N - 1 |
| x_pow | input | N | Minuend residue modulo 2^N |
| y_ones | input | N | Subtrahend residue modulo 2^N - 1 |
| y_pow | input | N | Subtrahend residue modulo 2^N |
| diff_ones | output | N | Difference residue modulo 2^N - 1, always in 0 to 2^N - 2 |
| diff_pow | output | N | Difference residue modulo 2^N |

## Verification
The bench covers every combination of all four 4-bit inputs. This includes every case where the ones lane wraps. It also covers equal operands, which produce the all-ones intermediate: a design without the final fold would output 15 instead of 0 there. Cases where the minuend exceeds the subtrahend produce an end-around carry. Leaving that carry out would make the ones lane one too small. Feeding it into the pow lane, or dropping the +1 in the pow lane, would shift `diff_pow` by one. The all-ones input codes are checked against the residue zero. Separate steps hold one lane still while the other lane's inputs change, to catch any leakage between lanes. An 8-bit instance is also driven with seeded random operands to exercise the default width.

// File: rtl/rns_sub_pkg.sv
package rns_sub_pkg;
  // Default residue width: moduli are 2^N-1 and 2^N.
  localparam int unsigned RNS_DEF_N = 8;

  // Lane selector, kept for documentation of lane identity.
  typedef enum logic {LANE_ONES = 1'b0, LANE_POW = 1'b1} rns_lane_e;
endpackage

// File: rtl/rns_ripple_add.sv
// W-bit ripple adder with carry in; sum carries the final carry in bit W.
module rns_ripple_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W:0]   sum
);
  logic [W:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]  = a[i] ^ b[i] ^ c[i];
    assign c[i+1]  = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
  end

  assign sum[W] = c[W];
endmodule

// File: rtl/rns_wrap_add.sv
// W-bit modulo-2^W adder: the top bit is a half sum, so no carry leaves it.
module rns_wrap_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);
  logic [W-1:0] low;

  generate
    if (W == 1) begin : g_single
      assign low[0] = cin;
      assign sum[0] = a[0] ^ b[0] ^ low[0];
    end else begin : g_multi
      rns_ripple_add #(.W(W-1)) u_low (
        .a   (a[W-2:0]),
        .b   (b[W-2:0]),
        .cin (cin),
        .sum (low)
      );
      assign sum[W-2:0] = low[W-2:0];
      assign sum[W-1]   = a[W-1] ^ b[W-1] ^ low[W-1];
    end
  endgenerate
endmodule

// File: rtl/rns_pow_lane.sv
// Modulo-2^N lane: x + ~y + 1 with the top carry discarded.
module rns_pow_lane #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N-1:0] d
);
  logic [N-1:0] y_inv;

  for (genvar i = 0; i < N; i++) begin : g_inv
    assign y_inv[i] = y[i] ^ 1'b1;
  end

  rns_wrap_add #(.W(N)) u_add (
    .a   (x),
    .b   (y_inv),
    .cin (1'b1),
    .sum (d)
  );
endmodule

// File: rtl/rns_ones_lane.sv
// Modulo-(2^N-1) lane: one's complement add of ~y with end-around carry.
module rns_ones_lane #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N-1:0] d
);
  localparam logic [N-1:0] ALL1 = {N{1'b1}};
  localparam logic [N-1:0] ZERO = '0;

  logic [N-1:0] x_n, y_n, y_inv, folded;
  logic [N:0]   first;

  // all-ones is the second code of zero; fold operands first
  assign x_n   = (x == ALL1) ? ZERO : x;
  assign y_n   = (y == ALL1) ? ZERO : y;
  assign y_inv = ~y_n;

  rns_ripple_add #(.W(N)) u_first (
    .a   (x_n),
    .b   (y_inv),
    .cin (1'b0),
    .sum (first)
  );

  // end-around carry; bounded operands keep this stage from carrying out
  rns_wrap_add #(.W(N)) u_wrap (
    .a   (first[N-1:0]),
    .b   (ZERO),
    .cin (first[N]),
    .sum (folded)
  );

  assign d = (folded == ALL1) ? ZERO : folded;
endmodule

// File: rtl/rns_pair_sub.sv
module rns_pair_sub #(
  parameter int unsigned N = rns_sub_pkg::RNS_DEF_N
) (
  input  logic [N-1:0] x_ones,
  input  logic [N-1:0] x_pow,
  input  logic [N-1:0] y_ones,
  input  logic [N-1:0] y_pow,
  output logic [N-1:0] diff_ones,
  output logic [N-1:0] diff_pow
);
  rns_ones_lane #(.N(N)) u_ones (
    .x (x_ones),
    .y (y_ones),
    .d (diff_ones)
  );

  rns_pow_lane #(.N(N)) u_pow (
    .x (x_pow),
    .y (y_pow),
    .d (diff_pow)
  );
endmodule

// File: rtl/rns_pair_sub_chk.sv
module rns_pair_sub_chk #(
  parameter int unsigned N = 8
) (
  input logic [N-1:0] x_ones,
  input logic [N-1:0] x_pow,
  input logic [N-1:0] y_ones,
  input logic [N-1:0] y_pow,
  input logic [N-1:0] diff_ones,
  input logic [N-1:0] diff_pow
);
  localparam longint M1 = (64'sd1 <<< N) - 1;
  localparam longint M2 = (64'sd1 <<< N);

  always_comb begin
    automatic longint xn = (x_ones == {N{1'b1}}) ? 0 : longint'(x_ones);
    automatic longint yn = (y_ones == {N{1'b1}}) ? 0 : longint'(y_ones);
    if (!$isunknown({x_ones, x_pow, y_ones, y_pow, diff_ones, diff_pow})) begin
      // R1
      pow_wrap_chk: assert (((longint'(diff_pow) + longint'(y_pow)) % M2) == longint'(x_pow));
      // R2
      ones_wrap_chk: assert (((longint'(diff_ones) + yn) % M1) == xn);
      // R3
      ones_canon_chk: assert (diff_ones != {N{1'b1}});
      // R3
      ones_equal_zero_chk: assert (!(xn == yn) || (diff_ones == '0));
    end
  end
endmodule

bind rns_pair_sub rns_pair_sub_chk #(.N(N)) u_chk (
  .x_ones    (x_ones),
  .x_pow     (x_pow),
  .y_ones    (y_ones),
  .y_pow     (y_pow),
  .diff_ones (diff_ones),
  .diff_pow  (diff_pow)
);

// File: tb/test_rns_pair_sub.sv
module test_rns_pair_sub;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   compared = 0;
  int   mismatched = 0;
  bit   done = 1'b0;
  int   wd_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0] xo4, xp4, yo4, yp4, do4, dp4;
  logic [7:0] xo8, xp8, yo8, yp8, do8, dp8;

  rns_pair_sub #(.N(4)) i_rns_pair_sub (
    .x_ones(xo4), .x_pow(xp4), .y_ones(yo4), .y_pow(yp4),
    .diff_ones(do4), .diff_pow(dp4));

  rns_pair_sub #(.N(8)) i_rns_pair_sub_w8 (
    .x_ones(xo8), .x_pow(xp8), .y_ones(yo8), .y_pow(yp8),
    .diff_ones(do8), .diff_pow(dp8));

  function automatic int ref_pow(int x, int y, int n);
    int m = 1 << n;
    return ((x - y) % m + m) % m;
  endfunction

  function automatic int ref_ones(int x, int y, int n);
    int m = (1 << n) - 1;
    int xn = (x == m) ? 0 : x;
    int yn = (y == m) ? 0 : y;
    return ((xn - yn) % m + m) % m;
  endfunction

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && !done) begin
      wd_cnt <= wd_cnt + 1;
      if (wd_cnt == WD_LIMIT) begin
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    int seed = 32'h5eed_0042;
    int dummy;
    logic [3:0] hold;
    xo4 = 0; xp4 = 0; yo4 = 0; yp4 = 0;
    xo8 = 0; xp8 = 0; yo8 = 0; yp8 = 0;
    dummy = $urandom(seed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6: zero operands settle without any clock edge
    #1;
    check("R6 ones zero", int'(do4), 0);
    check("R6 pow zero", int'(dp4), 0);

    // R7: directed example
    xo4 = 3; xp4 = 5; yo4 = 7; yp4 = 9; #1;
    check("R7 ones", int'(do4), 11);
    check("R7 pow", int'(dp4), 12);

    // R3: equal operands fold the all-ones intermediate to zero
    xo4 = 9; yo4 = 9; #1;
    check("R3 equal", int'(do4), 0);
    // R4: all-ones input acts as zero
    xo4 = 15; yo4 = 4; #1;
    check("R4 x all-ones", int'(do4), ref_ones(0, 4, 4));
    xo4 = 6; yo4 = 15; #1;
    check("R4 y all-ones", int'(do4), 6);
    xo4 = 15; yo4 = 0; #1;
    check("R4 both zero codes", int'(do4), 0);
    // R1: pow lane wraps at 2^N
    xp4 = 0; yp4 = 1; #1;
    check("R1 pow wrap", int'(dp4), 15);

    // R5: hold ones inputs, sweep pow inputs
    xo4 = 2; yo4 = 11; #1;
    hold = do4;
    for (int k = 0; k < 16; k++) begin
      xp4 = 4'(k); yp4 = 4'(15 - k); #1;
      check("R5 ones stable", int'(do4), int'(hold));
    end
    xp4 = 7; yp4 = 12; #1;
    hold = dp4;
    for (int k = 0; k < 16; k++) begin
      xo4 = 4'(k); yo4 = 4'(k * 3); #1;
      check("R5 pow stable", int'(dp4), int'(hold));
    end

    // R1 R2 R3 R4: exhaustive over all four 4-bit inputs
    for (int i = 0; i < 65536; i++) begin
      xo4 = 4'(i >> 12); yo4 = 4'(i >> 8); xp4 = 4'(i >> 4); yp4 = 4'(i);
      #1;
      check("R2 ones sweep", int'(do4), ref_ones(int'(xo4), int'(yo4), 4));
      check("R1 pow sweep", int'(dp4), ref_pow(int'(xp4), int'(yp4), 4));
    end

    // R1 R2: seeded random at default width
    for (int i = 0; i < 3000; i++) begin
      xo8 = 8'($urandom % 255); yo8 = 8'($urandom % 255);
      xp8 = 8'($urandom); yp8 = 8'($urandom);
      #1;
      check("R2 ones w8", int'(do8), ref_ones(int'(xo8), int'(yo8), 8));
      check("R1 pow w8", int'(dp8), ref_pow(int'(xp8), int'(yp8), 8));
    end
    xo8 = 8'hFF; yo8 = 8'd200; #1;
    check("R4 w8 all-ones", int'(do8), ref_ones(0, 200, 8));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule